// File: doc/BRIEF.md
# Indirect Branch Target Cache

This block predicts where an indirect branch will go. A front end presents a branch address together with the current global history and the last few indirect-branch targets. One cycle later the block returns a hit flag and a predicted target. When the branch resolves, the back end writes the real target through a separate update port. The update port carries its own address, history and path values, so it computes its own set index.

Storage is set-associative. The set is chosen by a hash. The hash starts from the aligned branch address and can fold in the global history, the recent path targets, or both. Each older path target is shifted a little further before it is folded in, so one static branch can occupy several sets, one for each distinct history context. The tag holds only aligned address bits.

Path history is supplied by the caller as a flat vector. Maintaining that history is the caller's job.

Top module: `itc_top`

## Requirements
- R1: The set index is the low log2(SETS) bits of a hash.
  - The hash starts as (pc >> SHIFT).
  - When USE_GHIST is set, it is XORed with the global history.
  - When USE_PATH is set, it is XORed with each path word p (p = 0 is the youngest, at bits [p*ADDR_W +: ADDR_W] of the path vector), shifted right by SHIFT + p*(log2(SETS)/PATH_LEN).
- R2: The tag is the low TAG_W bits of (pc >> SHIFT) and contains no history. A lookup whose history steers it to a set other than the one written misses.
- R3: After a synchronous active-low reset every way is invalid, so every lookup misses and the response outputs are low.
- R4: A lookup accepted in one cycle produces a response with the valid flag high in the next cycle. A cycle without a lookup produces a response with the valid flag low.
- R5: A lookup hits only when a valid way of the indexed set holds its tag, and then it returns that way's target. The lowest matching way wins. On a miss the target output is zero and the hit flag is low.
- R6: An update whose tag is already held in the indexed set overwrites that way's target in place. The tag never appears twice in a set, so the latest target is always returned.
- R7: An update whose tag is absent replaces the way picked by a free-running pseudo-random generator. A lookup issued on the cycle after the update returns the new target.
- R8: When a lookup and an update arrive in the same cycle, the lookup sees the contents from before the update.
- R9: A set holds at most WAYS entries. After more distinct tags than ways are written to one set, no more than WAYS of them hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | ADDR_W | Branch address for the lookup |
| lk_ghist | input | GHR_W | Global history for the lookup |
| lk_path | input | PATH_LEN*ADDR_W | Recent targets for the lookup, youngest in the low word |
| up_valid | input | 1 | Update request |
| up_pc | input | ADDR_W | Branch address for the update |
| up_ghist | input | GHR_W | Global history for the update |
| up_path | input | PATH_LEN*ADDR_W | Recent targets for the update |
| up_target | input | ADDR_W | Resolved target to store |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Response is a hit |
| rsp_target | output | ADDR_W | Predicted target, zero on a miss |

## Verification
The embedded assertions run on every cycle and check four things:
- the one-cycle response timing;
- that hit never appears without valid, and that a miss carries a zero target;
- that after every update the written tag is present exactly once in its set;
- that the replacement generator never locks up at zero.

Some behaviours can only be shown by bench scenarios. These are the exact hash folding of history and path words, the history-independent tag, the value returned after overwrites, and the ordering of a same-cycle lookup and update. The bench checks them against an independently computed index and a per-key model of the last target written.

// File: rtl/itc_pkg.sv
// itc_pkg: shared defaults and helpers for the indirect target cache.
// Assumes: callers pass power-of-two set counts.
package itc_pkg;
    localparam int ITC_ADDR_W   = 32;
    localparam int ITC_GHR_W    = 8;
    localparam int ITC_SETS     = 16;
    localparam int ITC_WAYS     = 4;
    localparam int ITC_TAG_W    = 10;
    localparam int ITC_PATH_LEN = 2;
    localparam int ITC_SHIFT    = 2;
    localparam int ITC_LFSR_W   = 8;

    // Width of a way selector; at least one bit.
    function automatic int way_bits(input int ways);
        return (ways > 1) ? $clog2(ways) : 1;
    endfunction
endpackage

// File: rtl/itc_set_hash.sv
// itc_set_hash: computes set index and tag for one access.
// Index = low bits of aligned pc ^ history ^ per-depth-shifted path words.
// Assumes ADDR_W covers SHIFT + (PATH_LEN-1)*step + log2(SETS) bits.
module itc_set_hash #(
    parameter int ADDR_W    = 32,
    parameter int GHR_W     = 8,
    parameter int SETS      = 16,
    parameter int TAG_W     = 10,
    parameter int PATH_LEN  = 2,
    parameter int SHIFT     = 2,
    parameter bit USE_GHIST = 1'b1,
    parameter bit USE_PATH  = 1'b1
) (
    input  logic [ADDR_W-1:0]          pc,
    input  logic [GHR_W-1:0]           ghist,
    input  logic [PATH_LEN*ADDR_W-1:0] path,
    output logic [$clog2(SETS)-1:0]    idx,
    output logic [TAG_W-1:0]           tag
);
    localparam int IDX_W = $clog2(SETS);
    localparam int STEP  = IDX_W / PATH_LEN;

    logic [GHR_W+IDX_W-1:0] gh_pad;
    logic                   unused_hash_in;

    assign gh_pad         = {{IDX_W{1'b0}}, ghist};
    assign unused_hash_in = ^{pc, path, gh_pad};

    // Fold the enabled history sources into the aligned address bits.
    always_comb begin
        idx = pc[SHIFT +: IDX_W];
        if (USE_GHIST) idx = idx ^ gh_pad[IDX_W-1:0];
        if (USE_PATH) begin
            for (int p = 0; p < PATH_LEN; p++) begin
                idx = idx ^ path[p*ADDR_W + SHIFT + p*STEP +: IDX_W];
            end
        end
    end

    // Tag carries address bits only.
    assign tag = pc[SHIFT +: TAG_W];
endmodule

// File: rtl/itc_lfsr.sv
// itc_lfsr: free-running Galois LFSR used as the replacement way source.
// Assumes TAPS describes a maximal-length polynomial for LFSR_W.
module itc_lfsr #(
    parameter int               LFSR_W = 8,
    parameter logic [LFSR_W-1:0] TAPS  = 8'hB8,
    parameter logic [LFSR_W-1:0] SEED  = 8'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [LFSR_W-1:0] state
);
    // Advance one step per cycle; reseed on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEED;
        else        state <= (state >> 1) ^ (state[0] ? TAPS : '0);
    end

    // R7: the generator must never reach the all-zero lock-up state
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);
endmodule

// File: rtl/itc_store.sv
// itc_store: tag/target arrays with per-way valid bits.
// Reads are combinational and registered into the response. Writes land at the clock edge,
// so a same-cycle lookup sees the old contents.
// Assumes WAYS >= 2 and that a tag appears at most once per set.
module itc_store #(
    parameter int ADDR_W = 32,
    parameter int SETS   = 16,
    parameter int WAYS   = 4,
    parameter int TAG_W  = 10,
    parameter int WAY_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lk_valid,
    input  logic [$clog2(SETS)-1:0] lk_idx,
    input  logic [TAG_W-1:0]        lk_tag,
    input  logic                    up_valid,
    input  logic [$clog2(SETS)-1:0] up_idx,
    input  logic [TAG_W-1:0]        up_tag,
    input  logic [ADDR_W-1:0]       up_target,
    input  logic [WAY_W-1:0]        rand_way,
    output logic                    rsp_valid,
    output logic                    rsp_hit,
    output logic [ADDR_W-1:0]       rsp_target
);
    localparam int IDX_W = $clog2(SETS);

    logic [WAYS-1:0]   vld_q [SETS];
    logic [TAG_W-1:0]  tag_q [SETS][WAYS];
    logic [ADDR_W-1:0] tgt_q [SETS][WAYS];

    logic              lk_hit;
    logic [ADDR_W-1:0] lk_tgt;
    logic              up_hit;
    logic [WAY_W-1:0]  up_match_way;
    logic [WAY_W-1:0]  wr_way;

    // Lookup compare: the lowest matching valid way wins.
    always_comb begin
        lk_hit = 1'b0;
        lk_tgt = '0;
        for (int w = WAYS-1; w >= 0; w--) begin
            if (vld_q[lk_idx][w] && tag_q[lk_idx][w] == lk_tag) begin
                lk_hit = 1'b1;
                lk_tgt = tgt_q[lk_idx][w];
            end
        end
    end

    // Update compare: find an existing copy of the tag.
    always_comb begin
        up_hit       = 1'b0;
        up_match_way = '0;
        for (int w = WAYS-1; w >= 0; w--) begin
            if (vld_q[up_idx][w] && tag_q[up_idx][w] == up_tag) begin
                up_hit       = 1'b1;
                up_match_way = WAY_W'(w);
            end
        end
        wr_way = up_hit ? up_match_way : rand_way;
    end

    // Valid bits: cleared on reset, set on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
        end else if (up_valid) begin
            vld_q[up_idx][wr_way] <= 1'b1;
        end
    end

    // Tag and target payload: written in place or at the chosen victim.
    always_ff @(posedge clk) begin
        if (up_valid) begin
            tag_q[up_idx][wr_way] <= up_tag;
            tgt_q[up_idx][wr_way] <= up_target;
        end
    end

    // Register the lookup response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_target <= '0;
        end else begin
            rsp_valid  <= lk_valid;
            rsp_hit    <= lk_valid && lk_hit;
            rsp_target <= (lk_valid && lk_hit) ? lk_tgt : '0;
        end
    end

    // Checker support: remember the last written set and tag.
    logic             chk_seen_q;
    logic [IDX_W-1:0] chk_idx_q;
    logic [TAG_W-1:0] chk_tag_q;
    int               chk_cnt;

    // Capture the write target for the post-write duplicate check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_seen_q <= 1'b0;
            chk_idx_q  <= '0;
            chk_tag_q  <= '0;
        end else begin
            chk_seen_q <= up_valid;
            chk_idx_q  <= up_idx;
            chk_tag_q  <= up_tag;
        end
    end

    // Count the copies of the written tag in its set.
    always_comb begin
        chk_cnt = 0;
        for (int w = 0; w < WAYS; w++) begin
            if (vld_q[chk_idx_q][w] && tag_q[chk_idx_q][w] == chk_tag_q) chk_cnt++;
        end
    end

    // R6
    single_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_seen_q |-> chk_cnt == 1);
    // R4
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    // R4
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);
    // R5
    hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);
    // R5
    miss_zero_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> rsp_target == '0);
endmodule

// File: rtl/itc_top.sv
// itc_top: indirect branch target cache.
// Two hash units (lookup and update), a replacement LFSR and the way store.
// Assumes SETS is a power of two and WAYS >= 2.
module itc_top
    import itc_pkg::*;
#(
    parameter int ADDR_W    = ITC_ADDR_W,
    parameter int GHR_W     = ITC_GHR_W,
    parameter int SETS      = ITC_SETS,
    parameter int WAYS      = ITC_WAYS,
    parameter int TAG_W     = ITC_TAG_W,
    parameter int PATH_LEN  = ITC_PATH_LEN,
    parameter int SHIFT     = ITC_SHIFT,
    parameter int LFSR_W    = ITC_LFSR_W,
    parameter bit USE_GHIST = 1'b1,
    parameter bit USE_PATH  = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       lk_valid,
    input  logic [ADDR_W-1:0]          lk_pc,
    input  logic [GHR_W-1:0]           lk_ghist,
    input  logic [PATH_LEN*ADDR_W-1:0] lk_path,
    input  logic                       up_valid,
    input  logic [ADDR_W-1:0]          up_pc,
    input  logic [GHR_W-1:0]           up_ghist,
    input  logic [PATH_LEN*ADDR_W-1:0] up_path,
    input  logic [ADDR_W-1:0]          up_target,
    output logic                       rsp_valid,
    output logic                       rsp_hit,
    output logic [ADDR_W-1:0]          rsp_target
);
    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = way_bits(WAYS);

    // R1: a power-of-two set count is required by the masked index
    initial sets_pow2_chk: assert ((SETS & (SETS - 1)) == 0 && SETS > 1);

    logic [IDX_W-1:0]  lk_idx, up_idx;
    logic [TAG_W-1:0]  lk_tag, up_tag;
    logic [LFSR_W-1:0] lfsr_state;
    logic [WAY_W-1:0]  rand_way;

    itc_set_hash #(.ADDR_W(ADDR_W), .GHR_W(GHR_W), .SETS(SETS), .TAG_W(TAG_W),
                   .PATH_LEN(PATH_LEN), .SHIFT(SHIFT),
                   .USE_GHIST(USE_GHIST), .USE_PATH(USE_PATH))
    lk_hash_i (.pc(lk_pc), .ghist(lk_ghist), .path(lk_path), .idx(lk_idx), .tag(lk_tag));

    itc_set_hash #(.ADDR_W(ADDR_W), .GHR_W(GHR_W), .SETS(SETS), .TAG_W(TAG_W),
                   .PATH_LEN(PATH_LEN), .SHIFT(SHIFT),
                   .USE_GHIST(USE_GHIST), .USE_PATH(USE_PATH))
    up_hash_i (.pc(up_pc), .ghist(up_ghist), .path(up_path), .idx(up_idx), .tag(up_tag));

    itc_lfsr #(.LFSR_W(LFSR_W)) lfsr_i (.clk(clk), .rst_n(rst_n), .state(lfsr_state));

    // Reduce the generator state to a legal way number.
    assign rand_way = WAY_W'(lfsr_state % LFSR_W'(WAYS));

    itc_store #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W))
    store_i (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_idx(lk_idx), .lk_tag(lk_tag),
        .up_valid(up_valid), .up_idx(up_idx), .up_tag(up_tag), .up_target(up_target),
        .rand_way(rand_way),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_target(rsp_target)
    );
endmodule

// File: tb/itc_top_tb.sv
// itc_top_tb_top: directed corners plus seeded random traffic for itc_top.
module itc_top_tb_top;
    localparam int AW = 32;
    localparam int GW = 8;
    localparam int NS = 16;
    localparam int NW = 4;
    localparam int TW = 10;
    localparam int PL = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 1'b0, up_valid = 1'b0;
    logic [AW-1:0] lk_pc = '0, up_pc = '0, up_target = '0;
    logic [GW-1:0] lk_ghist = '0, up_ghist = '0;
    logic [PL*AW-1:0] lk_path = '0, up_path = '0;
    logic          rsp_valid, rsp_hit;
    logic [AW-1:0] rsp_target;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;
    logic [AW-1:0] mdl [int];

    always #2 clk = ~clk;

    itc_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_ghist(lk_ghist), .lk_path(lk_path),
        .up_valid(up_valid), .up_pc(up_pc), .up_ghist(up_ghist), .up_path(up_path),
        .up_target(up_target),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_target(rsp_target)
    );

    // Expected set index computed from R1.
    function automatic int exp_idx(logic [AW-1:0] pc, logic [GW-1:0] g,
                                   logic [AW-1:0] p0, logic [AW-1:0] p1);
        logic [AW-1:0] h;
        h = (pc >> 2) ^ AW'(g) ^ (p0 >> 2) ^ (p1 >> 4);
        return int'(h & 32'hF);
    endfunction

    // Model key from the expected index and the R2 tag.
    function automatic int key_of(logic [AW-1:0] pc, logic [GW-1:0] g,
                                  logic [AW-1:0] p0, logic [AW-1:0] p1);
        return exp_idx(pc, g, p0, p1) * 1024 + int'((pc >> 2) & 32'h3FF);
    endfunction

    task automatic check(input bit ok, input string req, input logic [AW-1:0] act,
                         input logic [AW-1:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_lookup(input logic [AW-1:0] pc, input logic [GW-1:0] g,
                             input logic [AW-1:0] p0, input logic [AW-1:0] p1,
                             output logic hit, output logic [AW-1:0] tgt, output logic vld);
        @(negedge clk);
        lk_valid = 1'b1; lk_pc = pc; lk_ghist = g; lk_path = {p1, p0};
        @(negedge clk);
        hit = rsp_hit; tgt = rsp_target; vld = rsp_valid;
        lk_valid = 1'b0;
    endtask

    task automatic do_update(input logic [AW-1:0] pc, input logic [GW-1:0] g,
                             input logic [AW-1:0] p0, input logic [AW-1:0] p1,
                             input logic [AW-1:0] tgt);
        @(negedge clk);
        up_valid = 1'b1; up_pc = pc; up_ghist = g; up_path = {p1, p0}; up_target = tgt;
        mdl[key_of(pc, g, p0, p1)] = tgt;
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic h, v;
        logic [AW-1:0] t;
        int unsigned seed;
        int hits;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: reset state of the outputs and of the arrays
        check(rsp_valid == 0 && rsp_hit == 0, "R3 reset outputs", AW'({rsp_valid, rsp_hit}), 0);
        for (int i = 0; i < 8; i++) begin
            do_lookup($urandom, GW'($urandom), $urandom, $urandom, h, t, v);
            check(h == 0 && t == 0, "R3 miss after reset", t, 0);
        end

        // R4: response valid one cycle after a request, low when idle
        do_lookup(32'h40, 0, 0, 0, h, t, v);
        check(v == 1, "R4 response valid", AW'(v), 1);
        @(negedge clk);
        check(rsp_valid == 0, "R4 idle response", AW'(rsp_valid), 0);

        // R2 / R1: pc 0x100 maps to set 0 with no history
        do_update(32'h100, 0, 0, 0, 32'hCAFE0000);
        do_lookup(32'h100, 8'h1, 0, 0, h, t, v);
        check(h == 0, "R2 other set misses", AW'(h), 0);
        do_lookup(32'h100, 8'h1, 32'h4, 0, h, t, v);
        check(h == 1 && t == 32'hCAFE0000, "R1 depth0 path cancels history", t, 32'hCAFE0000);
        do_lookup(32'h100, 8'h1, 0, 32'h10, h, t, v);
        check(h == 1 && t == 32'hCAFE0000, "R1 depth1 shift cancels history", t, 32'hCAFE0000);
        do_lookup(32'h100, 8'h1, 0, 32'h4, h, t, v);
        check(h == 0, "R1 depth1 uses wider shift", AW'(h), 0);

        // R6: repeated overwrites return the latest target
        for (int i = 0; i < 8; i++) begin
            do_update(32'h48, 0, 0, 0, 32'h1000 + AW'(i));
            do_lookup(32'h48, 0, 0, 0, h, t, v);
            check(h == 1 && t == 32'h1000 + AW'(i), "R6 in-place overwrite", t, 32'h1000 + AW'(i));
        end

        // R9: six distinct tags into set 5
        for (int k = 1; k <= 6; k++) do_update(AW'(((k << 4) | 5) << 2), 0, 0, 0, AW'(k));
        hits = 0;
        for (int k = 1; k <= 6; k++) begin
            do_lookup(AW'(((k << 4) | 5) << 2), 0, 0, 0, h, t, v);
            if (h) begin
                hits++;
                check(t == AW'(k), "R5 hit target", t, AW'(k));
            end
        end
        check(hits <= NW && hits >= 1, "R9 set capacity", AW'(hits), NW);
        do_lookup(AW'(((6 << 4) | 5) << 2), 0, 0, 0, h, t, v);
        check(h == 1 && t == 6, "R7 newest allocation present", t, 6);

        // R8: same-cycle lookup and update in fresh set 9
        @(negedge clk);
        lk_valid = 1'b1; lk_pc = 32'hE4; lk_ghist = 0; lk_path = '0;
        up_valid = 1'b1; up_pc = 32'hE4; up_ghist = 0; up_path = '0; up_target = 32'hBEEF;
        mdl[key_of(32'hE4, 0, 0, 0)] = 32'hBEEF;
        @(negedge clk);
        check(rsp_hit == 0, "R8 lookup sees old contents", AW'(rsp_hit), 0);
        lk_valid = 1'b0; up_valid = 1'b0;
        do_lookup(32'hE4, 0, 0, 0, h, t, v);
        check(h == 1 && t == 32'hBEEF, "R8 update then visible", t, 32'hBEEF);

        // Random traffic over a small pool of branches and histories
        for (int n = 0; n < 400; n++) begin
            logic [AW-1:0] pc, p0, p1, tg;
            logic [GW-1:0] g;
            int key;
            pc = AW'(($urandom % 24) << 2) + 32'h2000;
            g  = GW'($urandom % 4);
            p0 = AW'(($urandom % 4) << 2);
            p1 = AW'(($urandom % 4) << 4);
            key = key_of(pc, g, p0, p1);
            if ($urandom % 2) begin
                tg = $urandom;
                do_update(pc, g, p0, p1, tg);
                do_lookup(pc, g, p0, p1, h, t, v);
                check(h == 1 && t == tg, "R7 written target returned", t, tg);
            end else begin
                do_lookup(pc, g, p0, p1, h, t, v);
                if (h) check(mdl.exists(key) && mdl[key] == t, "R5 random hit target", t,
                             mdl.exists(key) ? mdl[key] : '0);
                else   check(t == 0, "R5 random miss target", t, 0);
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule